// File: doc/BRIEF.md
# Two-Wire Serial Programming Target

This block is the device-side end of a two-wire programming link. An external programmer drives a serial clock and a data line; the block samples both with its own faster system clock, through two-flop synchronizers, and finds the serial clock edges in the system clock domain. Bits are taken on serial falling edges and given back on serial rising edges. The data pad is bidirectional: the block provides the output value and an output enable, and the pad itself sits outside.

A transaction starts with a six-bit command, sent least significant bit first. Only the low four bits select the operation. Load and Read are each followed by a sixteen-cycle data frame. In that frame the first cycle is a start bit, the last is a stop bit, and the fourteen cycles between carry a word least significant bit first. Of that word only the low twelve bits are kept. An eleven-bit address counter selects the program-memory word. The memory itself is outside the block and is reached through a simple port: an address, write data, a one-cycle write strobe and a one-cycle erase-all strobe, plus read data that must be valid for the current address.

Program mode is entered by raising the enable input. While that input is low, every register of the block is held in its idle state and the address counter is held at all-ones. A separate exit input drops any half-received command or frame, and the loaded word and the address counter are left as they were.

Top module: `sprog_target`

## Requirements
- R1: While `prog_en` is low, `sdat_oe`, `mem_we`, `mem_erase` and `busy` are 0 from the next clock, and `mem_addr` is 0x7FF, so entry into program mode always starts at address 0x7FF.
- R2: Command code 0x6 (low four bits) increments `mem_addr` by one. The counter wraps from 0x7FF to 0x000.
- R3: Command bits 5 and 4 are ignored: for example 0x36 acts as 0x6 and 0x34 acts as 0x4.
- R4: Command code 0x8 writes the last loaded 12-bit word at `mem_addr` with a one-cycle `mem_we` pulse and sets `busy`.
- R5: Code 0x2 is followed by a 16-cycle frame: start bit, 14 data bits LSb first taken on the falling edges of cycles 2 to 15, then a stop bit. Only data bits 11..0 are kept; bits 13 and 12 are ignored.
- R6: Code 0x4 is followed by a 16-cycle frame. The word at `mem_addr` is driven LSb first, one bit per rising edge from cycle 2 to cycle 15, and data bits 13 and 12 are driven as 0.
- R7: `sdat_oe` is 1 only from the rising edge of read-frame cycle 2 until the rising edge of the stop cycle.
- R8: Command code 0xE clears `busy`.
- R9: Command code 0x9 issues one `mem_erase` pulse, after which every memory word reads 0xFFF.
- R10: A `mode_exit` pulse drops a partial command or frame. The next full command then runs normally, and an aborted Load does not change the held word.
- R11: `mem_we` never stays high for two clocks in a row and is never high in the same clock as `mem_erase`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| prog_en | input | 1 | Program mode enable; low holds the block idle |
| mode_exit | input | 1 | One-cycle pulse that drops any partial command or frame |
| sclk_in | input | 1 | Serial clock from the programmer |
| sdat_in | input | 1 | Serial data arriving from the pad |
| sdat_out | output | 1 | Serial data going to the pad during Read |
| sdat_oe | output | 1 | Output enable for the data pad |
| mem_addr | output | 11 | Program-memory address (the address counter) |
| mem_wdata | output | 12 | Word to be written |
| mem_we | output | 1 | One-cycle write strobe |
| mem_erase | output | 1 | One-cycle erase-all strobe |
| mem_rdata | input | 12 | Word at `mem_addr` |
| busy | output | 1 | Set by a program command, cleared by end programming |

## Verification
The assertions check on every cycle the properties that can be seen locally: the idle state while the enable is low, the single step of the address counter, the output enable staying inside a read frame, the write and erase strobes being single and never together, and `busy` following the program and end commands. What no single-cycle property can show needs the bench scenarios. Those are the bit order and start/stop framing of whole Load and Read transfers, the masking of the upper data bits, the wrap at 0x7FF, ignored command bits, the effect of an aborted command or frame on the transfers that follow, and the memory contents after a bulk erase. The bench follows these with its own model of the address, `busy` and the memory.

// File: rtl/sprog_pkg.sv
package sprog_pkg;

  // Operation codes carried in the low four command bits
  localparam logic [3:0] OP_LOAD = 4'h2;
  localparam logic [3:0] OP_READ = 4'h4;
  localparam logic [3:0] OP_STEP = 4'h6;
  localparam logic [3:0] OP_PROG = 4'h8;
  localparam logic [3:0] OP_WIPE = 4'h9;
  localparam logic [3:0] OP_DONE = 4'hE;

  typedef enum logic [1:0] {
    LINK_CMD  = 2'd0,
    LINK_LOAD = 2'd1,
    LINK_READ = 2'd2
  } link_state_e;

  // True when the frame cycle index (falls completed) carries a data bit
  function automatic logic is_data_slot(input logic [3:0] idx, input int unsigned dw);
    return (idx >= 4'd1) && (32'(idx) <= dw);
  endfunction

endpackage

// File: rtl/sprog_sync.sv
module sprog_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= RST_VAL;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sprog_edge.sv
module sprog_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic s,
  output logic rise,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= s;
  end

  assign rise = s & ~prev;
  assign fall = ~s & prev;
endmodule

// File: rtl/sprog_link.sv
module sprog_link
  import sprog_pkg::*;
#(
  parameter int unsigned CW    = 6,
  parameter int unsigned DW    = 14,
  parameter int unsigned KW    = 12,
  parameter int unsigned FRAME = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          rise,
  input  logic          fall,
  input  logic          sdi,
  input  logic [KW-1:0] rd_word,
  output logic          cmd_valid,
  output logic [3:0]    cmd_code,
  output logic          load_done,
  output logic [KW-1:0] load_word,
  output logic          sdo,
  output logic          oe,
  output logic          rd_frame
);
  localparam int unsigned CNT_W = 4;
  localparam logic [CNT_W-1:0] CMD_LAST   = CNT_W'(CW - 1);
  localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME - 1);

  link_state_e      st;
  logic [CNT_W-1:0] cnt;
  logic [CW-1:0]    cmd_sr;
  logic [CW-1:0]    cmd_nxt;
  logic [DW-1:0]    ld_sr;
  logic [DW-1:0]    rd_sr;

  assign cmd_nxt   = {sdi, cmd_sr[CW-1:1]};
  assign load_word = ld_sr[KW-1:0];
  assign rd_frame  = (st == LINK_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= LINK_CMD;
      cnt       <= '0;
      cmd_sr    <= '0;
      ld_sr     <= '0;
      rd_sr     <= '0;
      cmd_valid <= 1'b0;
      cmd_code  <= '0;
      load_done <= 1'b0;
      sdo       <= 1'b0;
      oe        <= 1'b0;
    end else if (clr) begin
      st        <= LINK_CMD;
      cnt       <= '0;
      cmd_sr    <= '0;
      cmd_valid <= 1'b0;
      load_done <= 1'b0;
      sdo       <= 1'b0;
      oe        <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      load_done <= 1'b0;
      unique case (st)
        LINK_CMD: begin
          if (fall) begin
            cmd_sr <= cmd_nxt;
            if (cnt == CMD_LAST) begin
              cnt       <= '0;
              cmd_valid <= 1'b1;
              cmd_code  <= cmd_nxt[3:0];
              if (cmd_nxt[3:0] == OP_LOAD) begin
                st <= LINK_LOAD;
              end else if (cmd_nxt[3:0] == OP_READ) begin
                st    <= LINK_READ;
                rd_sr <= {{(DW-KW){1'b0}}, rd_word};
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        LINK_LOAD: begin
          if (fall) begin
            if (is_data_slot(cnt, DW)) ld_sr <= {sdi, ld_sr[DW-1:1]};
            if (cnt == FRAME_LAST) begin
              load_done <= 1'b1;
              st        <= LINK_CMD;
              cnt       <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        LINK_READ: begin
          if (rise) begin
            if (is_data_slot(cnt, DW)) begin
              sdo   <= rd_sr[0];
              rd_sr <= rd_sr >> 1;
              oe    <= 1'b1;
            end else if (cnt == FRAME_LAST) begin
              sdo <= 1'b0;
              oe  <= 1'b0;
            end
          end
          if (fall) begin
            if (cnt == FRAME_LAST) begin
              st  <= LINK_CMD;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: st <= LINK_CMD;
      endcase
    end
  end
endmodule

// File: rtl/sprog_target.sv
module sprog_target
  import sprog_pkg::*;
#(
  parameter int unsigned AW        = 11,
  parameter int unsigned KW        = 12,
  parameter int unsigned DW        = 14,
  parameter int unsigned CW        = 6,
  parameter int unsigned FRAME     = 16,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_en,
  input  logic          mode_exit,
  input  logic          sclk_in,
  input  logic          sdat_in,
  output logic          sdat_out,
  output logic          sdat_oe,
  output logic [AW-1:0] mem_addr,
  output logic [KW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_erase,
  input  logic [KW-1:0] mem_rdata,
  output logic          busy
);
  function automatic logic [AW-1:0] addr_step(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  logic          sclk_s, sdat_s;
  logic          sclk_rise, sclk_fall;
  logic          link_clr;
  logic          cmd_valid, load_done, rd_frame;
  logic [3:0]    cmd_code;
  logic [KW-1:0] load_word;
  logic [AW-1:0] addr_q;
  logic [KW-1:0] word_q;
  logic          inc_evt, end_evt;

  sprog_sync #(.STAGES(SYNC_STGS), .RST_VAL(1'b0)) u_sync_clk (
    .clk(clk), .rst_n(rst_n), .d(sclk_in), .q(sclk_s)
  );
  sprog_sync #(.STAGES(SYNC_STGS), .RST_VAL(1'b0)) u_sync_dat (
    .clk(clk), .rst_n(rst_n), .d(sdat_in), .q(sdat_s)
  );
  sprog_edge u_edge (
    .clk(clk), .rst_n(rst_n), .s(sclk_s), .rise(sclk_rise), .fall(sclk_fall)
  );

  assign link_clr = ~prog_en | mode_exit;

  sprog_link #(.CW(CW), .DW(DW), .KW(KW), .FRAME(FRAME)) u_link (
    .clk(clk), .rst_n(rst_n), .clr(link_clr),
    .rise(sclk_rise), .fall(sclk_fall), .sdi(sdat_s),
    .rd_word(mem_rdata),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .load_done(load_done), .load_word(load_word),
    .sdo(sdat_out), .oe(sdat_oe), .rd_frame(rd_frame)
  );

  assign inc_evt = cmd_valid && (cmd_code == OP_STEP);
  assign end_evt = cmd_valid && (cmd_code == OP_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '1;
      word_q    <= '0;
      busy      <= 1'b0;
      mem_we    <= 1'b0;
      mem_erase <= 1'b0;
    end else if (!prog_en) begin
      addr_q    <= '1;
      word_q    <= '0;
      busy      <= 1'b0;
      mem_we    <= 1'b0;
      mem_erase <= 1'b0;
    end else begin
      mem_we    <= 1'b0;
      mem_erase <= 1'b0;
      if (load_done) word_q <= load_word;
      if (cmd_valid) begin
        unique case (cmd_code)
          OP_STEP: addr_q <= addr_step(addr_q);
          OP_PROG: begin
            mem_we <= 1'b1;
            busy   <= 1'b1;
          end
          OP_DONE: busy      <= 1'b0;
          OP_WIPE: mem_erase <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = word_q;
endmodule

// File: rtl/sprog_target_chk.sv
module sprog_target_chk #(
  parameter int unsigned AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          prog_en,
  input logic          mode_exit,
  input logic          sdat_oe,
  input logic          mem_we,
  input logic          mem_erase,
  input logic          busy,
  input logic [AW-1:0] mem_addr,
  input logic          inc_evt,
  input logic          end_evt,
  input logic          rd_frame
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_en |=> (!sdat_oe && !mem_we && !mem_erase && !busy && (mem_addr == '1))); // R1

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_evt && prog_en) |=> (mem_addr == AW'($past(mem_addr) + 1'b1))); // R2

  AST_PROG_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R4

  AST_OE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    sdat_oe |-> rd_frame); // R7

  AST_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> !busy); // R8

  AST_EXIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_exit |=> (!sdat_oe && !rd_frame)); // R10

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we); // R11

  AST_WE_ERASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_erase)); // R11
endmodule

bind sprog_target sprog_target_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .mode_exit(mode_exit),
  .sdat_oe(sdat_oe), .mem_we(mem_we), .mem_erase(mem_erase), .busy(busy),
  .mem_addr(mem_addr), .inc_evt(inc_evt), .end_evt(end_evt), .rd_frame(rd_frame)
);

// File: tb/sprog_target_bench.sv
module sprog_target_bench;
  localparam int AW = 11, KW = 12, DW = 14, HALF = 8, DEPTH = 2048;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, prog_en, mode_exit, sclk, sdi;
  logic sdat_out, sdat_oe, mem_we, mem_erase, busy;
  logic [AW-1:0] mem_addr;
  logic [KW-1:0] mem_wdata, mem_rdata;

  logic [KW-1:0] mem     [DEPTH];
  logic [KW-1:0] ref_mem [DEPTH];
  int  checks = 0, errors = 0;
  int  ref_addr = 2047;
  int  ref_word = 0;
  bit  ref_busy = 0;
  bit  settled = 0, done = 0;
  logic prev_we = 1'b0;

  sprog_target u_sprog_target (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .mode_exit(mode_exit),
    .sclk_in(sclk), .sdat_in(sdi), .sdat_out(sdat_out), .sdat_oe(sdat_oe),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_erase(mem_erase), .mem_rdata(mem_rdata), .busy(busy)
  );

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (mem_erase) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 12'hFFF;
    end else if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Reference model compared on every clock
  always @(negedge clk) begin
    if (!done) begin
      if (settled) begin
        chk(mem_addr == AW'(ref_addr), "R2 address model", int'(mem_addr), ref_addr);
        chk(busy == ref_busy, "R8 busy model", int'(busy), int'(ref_busy));
      end
      if (mem_we || mem_erase) begin
        chk(!(mem_we && (mem_erase || prev_we)), "R11 strobe shape", int'({mem_we, mem_erase}), 2);
      end
      if (mem_we) begin
        chk(mem_wdata == KW'(ref_word) && mem_addr == AW'(ref_addr), "R4 write port",
            int'(mem_wdata), ref_word);
      end
      prev_we = mem_we;
    end
  end

  task automatic ser_cycle(input logic din, output logic dout, output logic oe);
    @(negedge clk);
    sclk = 1'b1;
    sdi  = din;
    repeat (HALF) @(negedge clk);
    dout = sdat_out;
    oe   = sdat_oe;
    sclk = 1'b0;
    repeat (HALF - 1) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [5:0] c);
    logic d, o;
    settled = 0;
    for (int i = 0; i < 6; i++) ser_cycle(c[i], d, o);
  endtask

  task automatic frame(input logic [13:0] w, output logic [13:0] r, output logic [15:0] oes);
    logic d, o;
    r = '0;
    for (int k = 0; k < 16; k++) begin
      ser_cycle((k >= 1 && k <= 14) ? w[k-1] : 1'b0, d, o);
      oes[k] = o;
      if (k >= 1 && k <= 14) r[k-1] = d;
    end
  endtask

  task automatic do_inc(input logic [5:0] c);
    send_cmd(c);
    ref_addr = (ref_addr == DEPTH - 1) ? 0 : ref_addr + 1;
    settled = 1;
  endtask

  task automatic do_load(input logic [5:0] c, input logic [13:0] w);
    logic [13:0] r;
    logic [15:0] o;
    send_cmd(c);
    frame(w, r, o);
    ref_word = int'(w) % 4096;
    settled = 1;
  endtask

  task automatic do_read(input logic [5:0] c, input string tag);
    logic [13:0] r;
    logic [15:0] o;
    send_cmd(c);
    frame(14'h0, r, o);
    chk(r == {2'b00, ref_mem[ref_addr]}, {"R6 read word ", tag}, int'(r), int'(ref_mem[ref_addr]));
    chk(o == 16'h7FFE, {"R7 oe window ", tag}, int'(o), 16'h7FFE);
    settled = 1;
  endtask

  task automatic do_prog();
    send_cmd(6'h08);
    ref_mem[ref_addr] = KW'(ref_word);
    ref_busy = 1;
    settled = 1;
  endtask

  task automatic do_end();
    send_cmd(6'h0E);
    ref_busy = 0;
    settled = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic d, o;
    logic [13:0] r;
    logic [15:0] oes;
    int bad;
    for (int i = 0; i < DEPTH; i++) begin
      mem[i]     <= KW'((i * 37 + 5) % 4096);
      ref_mem[i]  = KW'((i * 37 + 5) % 4096);
    end
    rst_n = 0; prog_en = 0; mode_exit = 0; sclk = 0; sdi = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1: idle state before entry
    chk(mem_addr == 11'h7FF, "R1 entry address", int'(mem_addr), 'h7FF);
    chk(!sdat_oe && !busy && !mem_we && !mem_erase, "R1 idle outputs",
        int'({sdat_oe, busy, mem_we, mem_erase}), 0);
    prog_en = 1;
    repeat (3) @(negedge clk);
    settled = 1;

    do_read(6'h04, "at 7FF");
    do_inc(6'h06);                         // R2 wrap to 000
    chk(mem_addr == 11'h000, "R2 wrap", int'(mem_addr), 0);
    do_inc(6'h36);                         // R3 upper bits ignored
    chk(mem_addr == 11'h001, "R3 ignored command bits", int'(mem_addr), 1);

    do_load(6'h02, 14'h3ABC);              // R5 upper data bits dropped
    do_prog();
    chk(busy == 1'b1, "R4 busy set", int'(busy), 1);
    chk(mem[1] == 12'hABC, "R5 stored word", int'(mem[1]), 'hABC);
    do_end();
    chk(busy == 1'b0, "R8 busy clear", int'(busy), 0);
    do_read(6'h34, "R3 upper bits on read");

    // R10: partial command dropped
    settled = 0;
    ser_cycle(1'b0, d, o); ser_cycle(1'b1, d, o); ser_cycle(1'b1, d, o);
    @(negedge clk); mode_exit = 1; @(negedge clk); mode_exit = 0;
    do_inc(6'h06);
    chk(mem_addr == 11'h002, "R10 after partial command", int'(mem_addr), 2);

    do_load(6'h02, 14'h1555);
    do_prog();
    do_end();
    do_read(6'h04, "word 555");
    do_inc(6'h06);

    // R10: aborted load keeps held word
    send_cmd(6'h02);
    for (int k = 0; k < 5; k++) ser_cycle(1'b1, d, o);
    @(negedge clk); mode_exit = 1; @(negedge clk); mode_exit = 0;
    settled = 1;
    do_prog();
    chk(mem[3] == 12'h555, "R10 aborted load", int'(mem[3]), 'h555);
    do_end();
    do_read(6'h04, "R10 after abort");

    // R9: bulk erase
    send_cmd(6'h09);
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 12'hFFF;
    settled = 1;
    do_read(6'h04, "R9 erased");
    do_inc(6'h06);
    do_read(6'h04, "R9 erased next");
    bad = 0;
    for (int i = 0; i < DEPTH; i++) if (mem[i] != 12'hFFF) bad++;
    chk(bad == 0, "R9 all words erased", bad, 0);

    // R1: leave and re-enter program mode
    do_load(6'h02, 14'h0123);
    do_prog();
    settled = 0;
    prog_en = 0;
    repeat (3) @(negedge clk);
    chk(mem_addr == 11'h7FF && !busy && !sdat_oe, "R1 re-entry reset",
        int'({busy, mem_addr}), 'h7FF);
    prog_en = 1;
    ref_addr = 2047; ref_busy = 0;
    repeat (3) @(negedge clk);
    settled = 1;
    do_read(6'h04, "R1 after re-entry");
    frame(14'h0, r, oes);
    chk(oes == 16'h0, "R7 no oe outside read", int'(oes), 0);

    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule